// File: doc/BRIEF.md
# Swap-Cell Gate Pulse Sequencer

This block times the electrode enables of a two-qubit swap cell. When a start request is taken, it switches the shuttle-gate lines on one at a time in a staggered ramp. While all of them are held on, it runs a repeating pulse train on the exchange-gate line. It then releases the shuttle lines one at a time in reverse order and raises a one-cycle completion flag. Every interval is counted in clock cycles. No input other than start and reset affects the sequence.

The exchange-gate train is built from two counters. A period counter (8 bits at the default 256-cycle period) sets the duty of each pulse: the line is high for the first 2 cycles of each period and low for the other 254. A repetition counter (5 bits at the default of 24) counts the periods. Both counters advance only inside the train window and are cleared outside it and by reset. A request that arrives while a sequence is running is ignored.

With the defaults (4 shuttle lines, 4 cycles per ramp step), one sequence is 4*4 + 24*256 + 4*4 + 1 = 6177 cycles long, counted from the first cycle after start is taken.

Top module: `gate_swap_seq`

## Requirements
- R1: While reset is applied and after it is released with start low, every shuttle line, the exchange line and the done flag are low.
- R2: Ramp-up: in the first cycle after start is taken in idle, line S1 (bit 0 of `s_en`) is on. Each further STEP_LEN cycles the next higher bit also turns on, until all S_LINES bits are on after (S_LINES-1)*STEP_LEN cycles.
- R3: During the train, `a_en` is high for the first A_ON cycles of every A_PERIOD-cycle period and low for the remaining A_PERIOD-A_ON cycles. The defaults are 2 high and 254 low.
- R4: The train lasts exactly A_REPS periods (24 rising edges of `a_en` by default) and is immediately followed by ramp-down.
- R5: Ramp-down: the highest bit of `s_en` turns off first, then the next lower bit every STEP_LEN cycles. The last step keeps all lines off for STEP_LEN cycles, and `done` is high for exactly the one cycle after that step.
- R6: Between any two consecutive cycles, at most one bit of `s_en` changes.
- R7: `start` is ignored from the cycle it is taken until the cycle `done` is high, that cycle included. Holding start high during a sequence does not lengthen or restart it.
- R8: A synchronous reset in mid-sequence drives all outputs low in the next cycle and clears both counters, so the next start produces a complete sequence of the full length.
- R9: `a_en` is low outside the train window and is high only while all shuttle lines are on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to run one swap sequence, sampled in idle only |
| s_en | output | S_LINES | Shuttle-gate enables, bit 0 is S1 |
| a_en | output | 1 | Exchange-gate enable |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its default parameters: four shuttle lines, 4-cycle ramp steps, a 256-cycle period with 2 cycles high, and 24 repetitions. At these values a full 6177-cycle sequence fits many times within the cycle budget, so every cycle of it is compared against a trace computed from the requirements. Among the cycles compared are the wrap of the 8-bit period counter and the final count of the 5-bit repetition counter, which are the boundaries where an off-by-one in either counter would show. Holding start high through a whole sequence and resetting halfway through the train exercise the ignore and clear rules.

// File: rtl/gswp_pkg.sv
package gswp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP_UP,
    ST_TRAIN,
    ST_RAMP_DN,
    ST_FINISH
  } seq_state_t;

  // Exchange-gate level for a given position inside one period.
  function automatic logic duty_high(input int unsigned phase,
                                     input int unsigned on_len);
    return phase < on_len;
  endfunction

  // Shuttle line level for a line number, the ramp step index and the state.
  function automatic logic line_level(input int unsigned line,
                                      input int unsigned idx,
                                      input int unsigned nlines,
                                      input seq_state_t  st);
    case (st)
      ST_RAMP_UP: return line <= idx;
      ST_TRAIN:   return 1'b1;
      ST_RAMP_DN: return (line + idx + 1) < nlines;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gswp_period_ctr.sv
module gswp_period_ctr #(
  parameter int A_PERIOD = 256,
  localparam int PW = (A_PERIOD > 1) ? $clog2(A_PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  output logic [PW-1:0] phase,
  output logic          wrap
);
  localparam logic [PW-1:0] PH_MAX = PW'(A_PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)       phase <= '0;
    else if (en) begin
      if (phase == PH_MAX) phase <= '0;
      else                 phase <= phase + 1'b1;
    end
  end

  assign wrap = en && (phase == PH_MAX);

  // R3: the period restarts from zero after its last cycle
  assert_period_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && phase == PH_MAX) |=> (phase == '0));

endmodule

// File: rtl/gswp_rep_ctr.sv
module gswp_rep_ctr #(
  parameter int A_REPS = 24,
  localparam int RW = (A_REPS > 1) ? $clog2(A_REPS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam logic [RW-1:0] REP_MAX = RW'(A_REPS - 1);

  logic [RW-1:0] reps;

  always_ff @(posedge clk) begin
    if (rst || clr) reps <= '0;
    else if (inc)   reps <= last ? '0 : reps + 1'b1;
  end

  assign last = (reps == REP_MAX);

  // R4: the repetition count never passes its final value
  assert_rep_bound_R4: assert property (@(posedge clk) disable iff (rst)
    reps <= REP_MAX);

endmodule

// File: rtl/gswp_cascade.sv
module gswp_cascade
  import gswp_pkg::*;
#(
  parameter int S_LINES  = 4,
  parameter int STEP_LEN = 4,
  localparam int CW = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1,
  localparam int IW = (S_LINES > 1) ? $clog2(S_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_state_t         st,
  output logic [S_LINES-1:0] s_en,
  output logic               step_last
);
  localparam logic [CW-1:0] CYC_MAX = CW'(STEP_LEN - 1);
  localparam logic [IW-1:0] IDX_MAX = IW'(S_LINES - 1);

  logic [CW-1:0] cyc;
  logic [IW-1:0] idx;
  logic          active;

  assign active = (st == ST_RAMP_UP) || (st == ST_RAMP_DN);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cyc <= '0;
      idx <= '0;
    end else if (cyc == CYC_MAX) begin
      cyc <= '0;
      idx <= (idx == IDX_MAX) ? '0 : idx + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign step_last = active && (cyc == CYC_MAX) && (idx == IDX_MAX);

  for (genvar i = 0; i < S_LINES; i++) begin : g_line
    assign s_en[i] = line_level(i, 32'(idx), S_LINES, st);
  end

  // R6: the shuttle lines move one at a time
  assert_one_line_step_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(s_en ^ $past(s_en)) <= 1));

endmodule

// File: rtl/gate_swap_seq.sv
module gate_swap_seq
  import gswp_pkg::*;
#(
  parameter int S_LINES  = 4,
  parameter int STEP_LEN = 4,
  parameter int A_PERIOD = 256,
  parameter int A_ON     = 2,
  parameter int A_REPS   = 24,
  localparam int PW = (A_PERIOD > 1) ? $clog2(A_PERIOD) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic [S_LINES-1:0] s_en,
  output logic               a_en,
  output logic               done
);
  seq_state_t    st, st_nx;
  logic [PW-1:0] phase;
  logic          wrap, rep_last, step_last, in_train, train_end;

  assign in_train  = (st == ST_TRAIN);
  assign train_end = wrap && rep_last;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:    if (start)     st_nx = ST_RAMP_UP;
      ST_RAMP_UP: if (step_last) st_nx = ST_TRAIN;
      ST_TRAIN:   if (train_end) st_nx = ST_RAMP_DN;
      ST_RAMP_DN: if (step_last) st_nx = ST_FINISH;
      default:                   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  gswp_period_ctr #(.A_PERIOD(A_PERIOD)) u_period (
    .clk(clk), .rst(rst), .clr(!in_train), .en(in_train),
    .phase(phase), .wrap(wrap)
  );

  gswp_rep_ctr #(.A_REPS(A_REPS)) u_reps (
    .clk(clk), .rst(rst), .clr(!in_train), .inc(wrap), .last(rep_last)
  );

  gswp_cascade #(.S_LINES(S_LINES), .STEP_LEN(STEP_LEN)) u_cascade (
    .clk(clk), .rst(rst), .st(st), .s_en(s_en), .step_last(step_last)
  );

  assign a_en = in_train && duty_high(32'(phase), A_ON);
  assign done = (st == ST_FINISH);

  // R9: exchange gate only pulses with every shuttle line held on
  assert_a_inside_window_R9: assert property (@(posedge clk) disable iff (rst)
    a_en |-> (&s_en));

  // R5: completion is a single-cycle flag
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: completion follows the ramp-down with every line released
  assert_done_after_ramp_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(st) == ST_RAMP_DN && s_en == '0));

  // R8: reset silences every output on the next cycle
  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (s_en == '0 && !a_en && !done));

endmodule

// File: tb/gate_swap_seq_tb.sv
`timescale 1ns/1ps
module gate_swap_seq_tb;
  localparam int NL   = 4;
  localparam int STEP = 4;
  localparam int PER  = 256;
  localparam int ON   = 2;
  localparam int REPS = 24;
  localparam int UPN  = NL * STEP;
  localparam int TRN  = REPS * PER;
  localparam int SEQ  = 2 * UPN + TRN + 1;   // cycles from first ramp cycle to done inclusive

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NL-1:0] s_en;
  logic          a_en, done;

  int tests = 0;
  int fails = 0;

  // walk statistics
  int mism, first_k, a_rise, a_hi, done_n, done_k, max_chg, a_out;
  logic [5:0] first_act, first_exp;
  logic [NL-1:0] s_at0, s_at1step;

  always #2.5 clk = ~clk;

  gate_swap_seq u_dut (.clk(clk), .rst(rst), .start(start),
                       .s_en(s_en), .a_en(a_en), .done(done));

  // expected {done, a, s} for cycle k after start is taken
  function automatic logic [5:0] expect_at(input int k);
    logic [NL-1:0] s;
    logic a, d;
    s = '0; a = 1'b0; d = 1'b0;
    if (k < 0) begin
    end else if (k < UPN) begin
      s = NL'((1 << (k / STEP + 1)) - 1);
    end else if (k < UPN + TRN) begin
      s = '1;
      a = ((k - UPN) % PER) < ON;
    end else if (k < 2 * UPN + TRN) begin
      s = NL'((1 << (NL - 1 - (k - UPN - TRN) / STEP)) - 1);
    end else if (k == SEQ - 1) begin
      d = 1'b1;
    end
    return {d, a, s};
  endfunction

  task automatic check(input string req, input logic ok,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue start and walk the whole sequence; start is held high on cycles
  // hold_from..hold_to (sampled at the edge ending that cycle).
  task automatic run_walk(input int hold_from, input int hold_to);
    logic [NL-1:0] prev;
    logic prev_a;
    logic [5:0] act, exp;
    mism = 0; first_k = -1; a_rise = 0; a_hi = 0; done_n = 0; done_k = -1;
    max_chg = 0; a_out = 0; first_act = '0; first_exp = '0;
    prev = '0; prev_a = 1'b0;
    start = 1'b1;
    for (int k = 0; k < SEQ + 4; k++) begin
      @(negedge clk);
      start = (k >= hold_from && k <= hold_to);
      act = {done, a_en, s_en};
      exp = expect_at(k);
      if (act !== exp) begin
        if (mism == 0) begin first_k = k; first_act = act; first_exp = exp; end
        mism++;
      end
      if (a_en && !prev_a) a_rise++;
      if (a_en) a_hi++;
      if (a_en && (k < UPN || k >= UPN + TRN)) a_out++;
      if (done) begin done_n++; done_k = k; end
      if ($countones(s_en ^ prev) > max_chg) max_chg = $countones(s_en ^ prev);
      if (k == 0) s_at0 = s_en;
      if (k == STEP) s_at1step = s_en;
      prev = s_en; prev_a = a_en;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 s_en in reset", s_en == '0, s_en, 0);
    check("R1 a_en in reset", a_en == 1'b0, a_en, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 outputs idle after reset", {done, a_en, s_en} == '0, {done, a_en, s_en}, 0);
  endtask

  task automatic t_full();
    run_walk(-5, -5);
    if (mism != 0)
      $display("  first mismatch at cycle %0d", first_k);
    check("R2/R3/R5 full trace", mism == 0, first_act, first_exp);
    check("R2 S1 on first cycle", s_at0 == 4'b0001, s_at0, 4'b0001);
    check("R2 S2 after one step", s_at1step == 4'b0011, s_at1step, 4'b0011);
    check("R4 exchange pulse count", a_rise == REPS, a_rise, REPS);
    check("R3 exchange high cycles", a_hi == REPS * ON, a_hi, REPS * ON);
    check("R5 done pulse count", done_n == 1, done_n, 1);
    check("R5 done cycle", done_k == SEQ - 1, done_k, SEQ - 1);
    check("R6 lines changed per clock", max_chg <= 1, max_chg, 1);
    check("R9 exchange outside window", a_out == 0, a_out, 0);
  endtask

  task automatic t_start_held();
    run_walk(0, SEQ - 1);
    check("R7 trace with start held", mism == 0, first_act, first_exp);
    check("R7 done once at nominal cycle", done_n == 1 && done_k == SEQ - 1, done_k, SEQ - 1);
  endtask

  task automatic t_reset_mid();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (UPN + 3 * PER + 1) @(negedge clk);  // land in the train, on a high cycle
    check("R8 exchange high before reset", a_en == 1'b1, a_en, 1);
    rst = 1'b1;
    @(negedge clk);
    check("R8 outputs low after reset", {done, a_en, s_en} == '0, {done, a_en, s_en}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 stays idle after reset", {done, a_en, s_en} == '0, {done, a_en, s_en}, 0);
    run_walk(-5, -5);
    check("R8 full trace after mid reset", mism == 0, first_act, first_exp);
    check("R8 full pulse count after mid reset", a_rise == REPS, a_rise, REPS);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_full();
    repeat (5) @(negedge clk);
    t_start_held();
    repeat (5) @(negedge clk);
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule